// File: doc/BRIEF.md
# Video RAM Transfer Strobe Controller

This block drives the shared data-transfer / output-enable strobe of a video RAM. During an ordinary access the strobe simply follows an active-low window input. When the active-low shift-load request is asserted, the strobe is pulled low at once, with no clock edge in between. The memory controller lowers this request ahead of the row strobe of the transfer cycle, so the strobe is already low when the row strobe asserts.

The strobe goes high again at the earlier of two events. One is the request being deasserted. The other is the fourth rising clock edge since the request fell. While the request is held low, the window input has no effect. Once the request has timed out, the strobe stays high until the request goes high again. Only then does the window input take control of the strobe again.

The length of the hold is set by a parameter, with four clock edges as the default. A small counter times the hold. A combinational selector then picks between the hold logic and the window input.

Top module: `xfer_oe_ctrl`

## Requirements
- R1: While the synchronous active-high reset is held, with the load request high (inactive) and the window high (inactive), the strobe is high.
- R2: When the load request goes low, the strobe goes low in the same cycle, before any rising clock edge.
- R3: If the load request returns high before the fourth rising clock edge after it fell, the strobe leaves the load state on that rise and then follows the window input.
- R4: If the load request stays low, the strobe stays low through the first three rising edges after the fall and goes high at the fourth.
- R5: While the load request is low and the hold has not expired, the strobe stays low whatever the window input does.
- R6: While the load request is high, the strobe equals the window input: low when the window is low (active), high when it is high.
- R7: After the hold expires with the load request still low, the strobe stays high even when the window is active. The window regains control only when the load request returns high.
- R8: A new fall of the load request after at least one cycle high restarts the hold, giving the full four edges again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the hold counts its rising edges |
| rst | input | 1 | Synchronous active-high reset |
| load_req_n | input | 1 | Shift-register load request, active low |
| window_n | input | 1 | Window access input, active low |
| xfer_oe_n | output | 1 | Combined transfer / output-enable strobe, active low |

## Verification
Every cycle, assertions check four things: the counter never passes the hold length, a fresh fall finds the counter cleared, the strobe is low during an unexpired load, and the strobe is forced high once the hold has expired. Some behaviours appear only between clock edges or over a whole scenario, so only the bench's scenarios can show them. These are the immediate fall ahead of any edge, the exact edge of release for short and long loads, the window returning to control after the request rises, and the hold restarting on back-to-back loads.

// File: rtl/xfer_oe_pkg.sv
package xfer_oe_pkg;
  parameter int unsigned XFER_HOLD_DEFAULT = 4;

  function automatic int unsigned hold_cnt_width(input int unsigned hold);
    return (hold < 2) ? 1 : $clog2(hold + 1);
  endfunction
endpackage

// File: rtl/xfer_hold_timer.sv
module xfer_hold_timer #(
  parameter int unsigned HOLD_CLKS = xfer_oe_pkg::XFER_HOLD_DEFAULT,
  localparam int unsigned CW = xfer_oe_pkg::hold_cnt_width(HOLD_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req_n,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CLKS);

  logic [CW-1:0] cnt_q;

  // Cleared while the request is high, so a fall always starts from zero;
  // saturates at the hold length while the request stays low.
  always_ff @(posedge clk) begin
    if (rst || load_req_n) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LIMIT);

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  assert_fresh_start_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(load_req_n) && !load_req_n) |-> (cnt_q == '0));

  assert_release_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (!load_req_n && cnt_q == LIMIT - 1'b1) |=> (load_req_n || expired_o));
endmodule

// File: rtl/xfer_strobe_mux.sv
module xfer_strobe_mux (
  input  logic load_req_n,
  input  logic window_n,
  input  logic expired,
  output logic strobe_n
);
  always_comb begin
    if (load_req_n) begin
      strobe_n = window_n;
    end else begin
      strobe_n = expired;
    end
  end
endmodule

// File: rtl/xfer_oe_ctrl.sv
module xfer_oe_ctrl #(
  parameter int unsigned HOLD_CLKS = xfer_oe_pkg::XFER_HOLD_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic load_req_n,
  input  logic window_n,
  output logic xfer_oe_n
);
  localparam int unsigned CW = xfer_oe_pkg::hold_cnt_width(HOLD_CLKS);

  logic [CW-1:0] hold_cnt;
  logic          hold_expired;

  xfer_hold_timer #(.HOLD_CLKS(HOLD_CLKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_req_n (load_req_n),
    .cnt_o      (hold_cnt),
    .expired_o  (hold_expired)
  );

  xfer_strobe_mux u_mux (
    .load_req_n (load_req_n),
    .window_n   (window_n),
    .expired    (hold_expired),
    .strobe_n   (xfer_oe_n)
  );

  assert_load_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!load_req_n && !hold_expired) |-> !xfer_oe_n);

  assert_gated_high_R7: assert property (@(posedge clk) disable iff (rst)
    (!load_req_n && hold_expired) |-> xfer_oe_n);

  assert_fall_low_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(load_req_n) && !load_req_n) |-> !xfer_oe_n);
endmodule

// File: tb/xfer_oe_ctrl_bench.sv
`timescale 1ns/1ps
module xfer_oe_ctrl_bench;
  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_req_n = 1'b1;
  logic window_n = 1'b1;
  logic xfer_oe_n;

  int checks = 0;
  int errors = 0;
  item_t sb_q[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xfer_oe_ctrl u_xfer_oe_ctrl (
    .clk        (clk),
    .rst        (rst),
    .load_req_n (load_req_n),
    .window_n   (window_n),
    .xfer_oe_n  (xfer_oe_n)
  );

  // Driver: change inputs at the falling edge, then queue the expected strobe.
  task automatic step(input logic ld, input logic win, input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    load_req_n = ld;
    window_n   = win;
    #1;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare queued items, well away from the rising edge.
  always @(negedge clk) begin
    #2;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (xfer_oe_n !== it.exp) begin
        errors++;
        $display("FAIL %s: xfer_oe_n=%b expected %b", it.tag, xfer_oe_n, it.exp);
      end
    end
  end

  initial begin
    // R1 reset state
    step(1'b1, 1'b1, 1'b1, "R1 reset");
    step(1'b1, 1'b1, 1'b1, "R1 reset");
    @(negedge clk); rst = 1'b0;
    // R6 follow window
    step(1'b1, 1'b0, 1'b0, "R6 window active");
    step(1'b1, 1'b1, 1'b1, "R6 window idle");
    // R2/R3 short load
    step(1'b0, 1'b1, 1'b0, "R2 immediate fall");
    step(1'b0, 1'b1, 1'b0, "R3 short held");
    step(1'b1, 1'b1, 1'b1, "R3 short release");
    step(1'b1, 1'b0, 1'b0, "R3 window after short");
    step(1'b1, 1'b1, 1'b1, "R6 idle");
    // R4/R5/R7 long load with window toggling
    step(1'b0, 1'b1, 1'b0, "R2 long fall");
    step(1'b0, 1'b0, 1'b0, "R5 win active edge1");
    step(1'b0, 1'b1, 1'b0, "R5 win idle edge2");
    step(1'b0, 1'b0, 1'b0, "R4 edge3 still low");
    step(1'b0, 1'b0, 1'b1, "R4 edge4 release");
    step(1'b0, 1'b0, 1'b1, "R7 gated while low");
    step(1'b0, 1'b1, 1'b1, "R7 gated idle");
    step(1'b1, 1'b0, 1'b0, "R7 window regains");
    // R8 back-to-back restart after one high cycle
    step(1'b0, 1'b1, 1'b0, "R8 restart fall");
    step(1'b0, 1'b1, 1'b0, "R8 edge1");
    step(1'b0, 1'b1, 1'b0, "R8 edge2");
    step(1'b0, 1'b1, 1'b0, "R8 edge3");
    step(1'b0, 1'b1, 1'b1, "R8 edge4 release");
    step(1'b1, 1'b1, 1'b1, "R6 idle after");
    // R3 boundary: rises right at the fourth edge, window active
    step(1'b0, 1'b0, 1'b0, "R3 boundary fall");
    step(1'b0, 1'b0, 1'b0, "R3 boundary edge1");
    step(1'b0, 1'b0, 1'b0, "R3 boundary edge2");
    step(1'b0, 1'b0, 1'b0, "R3 boundary edge3");
    step(1'b1, 1'b0, 1'b0, "R3 boundary rise follows window");
    step(1'b1, 1'b1, 1'b1, "R6 final idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule